// File: doc/BRIEF.md
# Discharge-Time Pixel Array Scanner

This block is the digital measurement engine for a two-dimensional array of charge/discharge sensor pixels. It works on one pixel at a time. First it charges the row that holds the pixel, using a row enable strobe that lasts one clock. Then it lets the node float, opens that row's outputs onto the column lines and counts clock cycles while the selected column stays high. The count is a time-mode measure of the pixel's discharge time constant. It stops when the pixel's self-resetting latch drops or when the counter reaches its ceiling. The ceiling value means the reading is out of range.

The block has only serial pins. A serial input carries short commands: one command scans the whole array and another measures a single addressed pixel. Each result leaves the block as a fixed-width frame on a single serial output. A scan does not move on to the next pixel until the current frame has been shifted out completely. The default array is 234 rows by 23 columns with a 20-bit counter.

Top module: `pixel_scan_engine`

## Requirements
- R1: While `rst` is high at a clock edge, all `row_en` and `row_rd` lines are low after that edge, `ser_out` is low, and the engine is idle.
- R2: A measurement starts with exactly one `row_en` line, the one for the selected row, held high for exactly one clock.
- R3: In the clock after the charge strobe, `row_en` is all low and the same row's `row_rd` line is high. It stays high, one-hot, for the whole counting window, and `row_en` and `row_rd` are never high together.
- R4: The result is the number of read cycles in which the selected column was sampled high. A column that is already low in the first read cycle gives a count of 0. Counting ends in the first read cycle that samples the column low.
- R5: The count saturates at 2^CNT_W-1. When it reaches that value, reading stops even if the column is still high, so there are never more than 2^CNT_W-1 read cycles.
- R6: A result goes out as a one-clock marker at level 1, followed by a FRAME_W-bit frame sent MSB first. The frame is an 8-bit row index, then a 5-bit column index, then zero fill, with the count in the CNT_W least significant bits. By default this is 40 bits with 7 fill bits.
- R7: A full scan measures every pixel once. The column index advances fastest, then the row index. Every pixel gets its own charge strobe.
- R8: A command is a start bit at level 1 followed by 8 command bits, least significant bit first, one bit per clock. Command value 0x01 starts a full scan.
- R9: Command value 0x02 is followed by 8 row address bits and then 5 column address bits, each least significant bit first. It measures only that pixel, sends one frame and returns to idle.
- R10: A command value other than 0x01 or 0x02, and a 0x02 command whose row or column is outside the array, cause no strobe and no frame.
- R11: While a frame is being shifted out, all `row_en` and `row_rd` lines stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; its period sets the count resolution |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial command input, idle low |
| col_data | input | COLS | Pixel outputs of the row being read, one per column |
| ser_out | output | 1 | Serial result output: marker, then frame MSB first |
| row_en | output | ROWS | One-hot charge strobe per row |
| row_rd | output | ROWS | One-hot output-enable per row during counting |

## Verification
The bench models the array as a table of discharge lengths: each column stays high for a set number of read cycles after its row is charged. Single-pixel runs use lengths of zero, a short mid-range value, one below the ceiling, exactly the ceiling and far above it. These separate the zero case, normal counting, the exact stopping cycle and saturation. The number of read cycles is checked along with the reported count. A full scan with differing lengths per pixel shows whether the walk order, the per-pixel recharge and the row and column fields in each frame agree. Unknown commands and out-of-range addresses are sent to show that they are rejected and not turned into a measurement.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHARGE,
      ST_READ,
      ST_SEND
   } seq_st_t;

   typedef enum logic [1:0] {
      RX_WAIT,
      RX_CMD,
      RX_ADDR
   } rx_st_t;

   localparam int          CMD_BITS = 8;
   localparam logic [7:0]  OP_SCAN  = 8'h01;
   localparam logic [7:0]  OP_ONE   = 8'h02;
endpackage

// File: rtl/cmd_rx.sv
module cmd_rx
   import scan_pkg::*;
#(
   parameter int ROWS    = 234,
   parameter int COLS    = 23,
   parameter int ROW_FLD = 8,
   parameter int COL_FLD = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               listen,
   input  logic               ser_in,
   output logic               go_scan,
   output logic               go_one,
   output logic [ROW_FLD-1:0] tgt_row,
   output logic [COL_FLD-1:0] tgt_col
);
   localparam int ADR_W = ROW_FLD + COL_FLD;
   localparam int BC_W  = $clog2(ADR_W + CMD_BITS + 1);

   rx_st_t              st;
   logic [BC_W-1:0]     bcnt;
   logic [CMD_BITS-1:0] op_q;
   logic [ADR_W-1:0]    adr_q;
   logic [CMD_BITS-1:0] op_nx;
   logic [ADR_W-1:0]    adr_nx;
   logic [ROW_FLD-1:0]  row_nx;
   logic [COL_FLD-1:0]  col_nx;
   logic                in_range;

   always_comb begin
      op_nx    = {ser_in, op_q[CMD_BITS-1:1]};
      adr_nx   = {ser_in, adr_q[ADR_W-1:1]};
      row_nx   = adr_nx[ROW_FLD-1:0];
      col_nx   = adr_nx[ADR_W-1:ROW_FLD];
      in_range = (int'(row_nx) < ROWS) && (int'(col_nx) < COLS);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= RX_WAIT;
         bcnt    <= '0;
         op_q    <= '0;
         adr_q   <= '0;
         go_scan <= 1'b0;
         go_one  <= 1'b0;
         tgt_row <= '0;
         tgt_col <= '0;
      end else begin
         go_scan <= 1'b0;
         go_one  <= 1'b0;
         if (!listen) begin
            st <= RX_WAIT;
         end else begin
            case (st)
               RX_WAIT: begin
                  if (ser_in) begin
                     st   <= RX_CMD;
                     bcnt <= '0;
                  end
               end
               RX_CMD: begin
                  op_q <= op_nx;
                  bcnt <= bcnt + 1'b1;
                  if (bcnt == BC_W'(CMD_BITS - 1)) begin
                     bcnt <= '0;
                     if (op_nx == OP_SCAN) begin
                        go_scan <= 1'b1;
                        st      <= RX_WAIT;
                     end else if (op_nx == OP_ONE) begin
                        st <= RX_ADDR;
                     end else begin
                        st <= RX_WAIT;
                     end
                  end
               end
               RX_ADDR: begin
                  adr_q <= adr_nx;
                  bcnt  <= bcnt + 1'b1;
                  if (bcnt == BC_W'(ADR_W - 1)) begin
                     st <= RX_WAIT;
                     if (in_range) begin
                        go_one  <= 1'b1;
                        tgt_row <= row_nx;
                        tgt_col <= col_nx;
                     end
                  end
               end
               default: st <= RX_WAIT;
            endcase
         end
      end
   end
endmodule

// File: rtl/disch_counter.sv
module disch_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             sample_en,
   input  logic             pix,
   output logic             done,
   output logic [CNT_W-1:0] result
);
   localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] LAST = CEIL - 1'b1;

   logic [CNT_W-1:0] cnt;
   logic             bump;

   always_comb begin
      bump   = sample_en && pix && (cnt != CEIL);
      result = bump ? cnt + 1'b1 : cnt;
      done   = sample_en && (!pix || (cnt == LAST) || (cnt == CEIL));
   end

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (bump)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
   parameter int FRAME_W = 40
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   output logic               ser_out,
   output logic               tx_last
);
   localparam int LW = $clog2(FRAME_W + 2);

   logic [FRAME_W:0] sh;
   logic [LW-1:0]    left;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh   <= '0;
         left <= '0;
      end else if (load) begin
         sh   <= {1'b1, frame};
         left <= LW'(FRAME_W + 1);
      end else if (left != '0) begin
         sh   <= {sh[FRAME_W-1:0], 1'b0};
         left <= left - 1'b1;
      end
   end

   assign ser_out = (left != '0) && sh[FRAME_W];
   assign tx_last = (left == LW'(1));
endmodule

// File: rtl/row_strobe.sv
module row_strobe #(
   parameter int ROWS  = 234,
   parameter int IDX_W = 8
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             chg,
   input  logic             rd,
   output logic [ROWS-1:0]  row_en,
   output logic [ROWS-1:0]  row_rd
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic hit;
      assign hit       = (idx == IDX_W'(r));
      assign row_en[r] = chg && hit;
      assign row_rd[r] = rd && hit;
   end
endmodule

// File: rtl/pixel_scan_engine.sv
module pixel_scan_engine
   import scan_pkg::*;
#(
   parameter int ROWS    = 234,
   parameter int COLS    = 23,
   parameter int CNT_W   = 20,
   parameter int ROW_FLD = 8,
   parameter int COL_FLD = 5,
   parameter int FRAME_W = 40
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ser_in,
   input  logic [COLS-1:0] col_data,
   output logic            ser_out,
   output logic [ROWS-1:0] row_en,
   output logic [ROWS-1:0] row_rd
);
   localparam int PAD_W = FRAME_W - ROW_FLD - COL_FLD - CNT_W;

   if (ROWS < 1 || ROWS > (1 << ROW_FLD)) begin : g_bad_rows
      $error("ROWS does not fit the row field");
   end
   if (COLS < 1 || COLS > (1 << COL_FLD)) begin : g_bad_cols
      $error("COLS does not fit the column field");
   end
   if (PAD_W < 0) begin : g_bad_frame
      $error("FRAME_W too small for its fields");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   seq_st_t            st;
   logic [ROW_FLD-1:0] cur_row;
   logic [COL_FLD-1:0] cur_col;
   logic               scan_all;
   logic               go_scan, go_one;
   logic [ROW_FLD-1:0] tgt_row;
   logic [COL_FLD-1:0] tgt_col;
   logic               pix, meas_done, tx_last;
   logic [CNT_W-1:0]   result;
   logic [FRAME_W-1:0] frame;
   logic               row_last, col_last;
   logic [COLS-1:0]    col_hit;

   cmd_rx #(
      .ROWS(ROWS), .COLS(COLS), .ROW_FLD(ROW_FLD), .COL_FLD(COL_FLD)
   ) u_rx (
      .clk(clk), .rst(rst), .listen(st == ST_IDLE), .ser_in(ser_in),
      .go_scan(go_scan), .go_one(go_one),
      .tgt_row(tgt_row), .tgt_col(tgt_col)
   );

   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign col_hit[c] = col_data[c] && (cur_col == COL_FLD'(c));
   end
   assign pix = |col_hit;

   disch_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(st == ST_CHARGE),
      .sample_en(st == ST_READ), .pix(pix),
      .done(meas_done), .result(result)
   );

   if (PAD_W > 0) begin : g_pad
      assign frame = {cur_row, cur_col, {PAD_W{1'b0}}, result};
   end else begin : g_nopad
      assign frame = {cur_row, cur_col, result};
   end

   frame_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk(clk), .rst(rst), .load(meas_done), .frame(frame),
      .ser_out(ser_out), .tx_last(tx_last)
   );

   row_strobe #(.ROWS(ROWS), .IDX_W(ROW_FLD)) u_rows (
      .idx(cur_row), .chg(st == ST_CHARGE), .rd(st == ST_READ),
      .row_en(row_en), .row_rd(row_rd)
   );

   assign row_last = (cur_row == ROW_FLD'(ROWS - 1));
   assign col_last = (cur_col == COL_FLD'(COLS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         cur_row  <= '0;
         cur_col  <= '0;
         scan_all <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (go_scan) begin
                  cur_row  <= '0;
                  cur_col  <= '0;
                  scan_all <= 1'b1;
                  st       <= ST_CHARGE;
               end else if (go_one) begin
                  cur_row  <= tgt_row;
                  cur_col  <= tgt_col;
                  scan_all <= 1'b0;
                  st       <= ST_CHARGE;
               end
            end
            ST_CHARGE: st <= ST_READ;
            ST_READ:   if (meas_done) st <= ST_SEND;
            ST_SEND: begin
               if (tx_last) begin
                  if (scan_all && !(row_last && col_last)) begin
                     st <= ST_CHARGE;
                     if (col_last) begin
                        cur_col <= '0;
                        cur_row <= cur_row + 1'b1;
                     end else begin
                        cur_col <= cur_col + 1'b1;
                     end
                  end else begin
                     st       <= ST_IDLE;
                     scan_all <= 1'b0;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/scan_engine_chk.sv
module scan_engine_chk #(
   parameter int ROWS  = 234,
   parameter int CNT_W = 20
) (
   input logic            clk,
   input logic            rst,
   input logic            ser_out,
   input logic [ROWS-1:0] row_en,
   input logic [ROWS-1:0] row_rd
);
   localparam logic [CNT_W:0] RUN_MAX = {(CNT_W+1){1'b1}};
   localparam logic [CNT_W:0] CEIL    = {1'b0, {CNT_W{1'b1}}};

   logic [CNT_W:0] run;

   always_ff @(posedge clk) begin
      if (rst)                             run <= '0;
      else if (!(|row_rd))                 run <= '0;
      else if (run != RUN_MAX)             run <= run + 1'b1;
   end

   AST_RST_QUIET: assert property (@(posedge clk)
      rst |=> (row_en == '0 && row_rd == '0 && !ser_out)); // R1
   AST_CHG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_en)); // R2
   AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (|row_en) |=> (row_en == '0)); // R2
   AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (|row_en) |=> (row_rd == $past(row_en))); // R3
   AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_rd)); // R3
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      !((|row_en) && (|row_rd))); // R3
   AST_RD_BOUND: assert property (@(posedge clk) disable iff (rst)
      (|row_rd) |-> (run < CEIL)); // R5
   AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
      ser_out |-> (row_en == '0 && row_rd == '0)); // R11
endmodule

bind pixel_scan_engine scan_engine_chk #(.ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .ser_out(ser_out), .row_en(row_en), .row_rd(row_rd)
);

// File: tb/tb_pixel_scan_engine.sv
module tb_pixel_scan_engine;
   localparam int TR   = 4;
   localparam int TC   = 3;
   localparam int TW   = 6;
   localparam int MAXC = (1 << TW) - 1;
   localparam int FW   = 40;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ser_in = 1'b0;
   logic [TC-1:0] col_data;
   logic          ser_out;
   logic [TR-1:0] row_en, row_rd;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   int dly  [TR][TC];
   int left [TC];
   int en_pulses = 0, rd_cycles = 0, tx_hi = 0;

   always #5 clk = ~clk;

   pixel_scan_engine #(.ROWS(TR), .COLS(TC), .CNT_W(TW)) dut (
      .clk(clk), .rst(rst), .ser_in(ser_in), .col_data(col_data),
      .ser_out(ser_out), .row_en(row_en), .row_rd(row_rd)
   );

   // array model: a charged column stays high for dly read cycles
   always @(posedge clk) begin
      for (int r = 0; r < TR; r++)
         if (row_en[r])
            for (int c = 0; c < TC; c++) left[c] <= dly[r][c];
      if (|row_rd)
         for (int c = 0; c < TC; c++)
            if (left[c] > 0) left[c] <= left[c] - 1;
   end

   always_comb
      for (int c = 0; c < TC; c++) col_data[c] = (|row_rd) && (left[c] > 0);

   always @(negedge clk) begin
      cycles++;
      if (!rst) begin
         if (|row_en) en_pulses++;
         if (|row_rd) rd_cycles++;
         if (ser_out) tx_hi++;
      end
      if (cycles > 150000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_mon();
      en_pulses = 0; rd_cycles = 0; tx_hi = 0;
   endtask

   task automatic send_cmd(input logic [7:0] op, input bit with_adr,
                           input logic [7:0] r, input logic [4:0] c);
      @(negedge clk) ser_in = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk) ser_in = op[i];
      end
      if (with_adr) begin
         for (int i = 0; i < 8; i++) begin
            @(negedge clk) ser_in = r[i];
         end
         for (int i = 0; i < 5; i++) begin
            @(negedge clk) ser_in = c[i];
         end
      end
      @(negedge clk) ser_in = 1'b0;
   endtask

   task automatic get_frame(output logic [FW-1:0] f, output bit got, output bit quiet);
      got = 0; quiet = 1; f = '0;
      for (int i = 0; i < 3000 && !got; i++) begin
         @(negedge clk);
         if (ser_out) got = 1;
      end
      if (got)
         for (int i = FW - 1; i >= 0; i--) begin
            @(negedge clk);
            f[i] = ser_out;
            if (row_en != '0 || row_rd != '0) quiet = 0;
         end
   endtask

   function automatic int expect_cnt(input int d);
      return (d < MAXC) ? d : MAXC;
   endfunction

   task automatic t_reset();
      chk(row_en == '0, "R1 row_en in reset", int'(row_en), 0);
      chk(row_rd == '0, "R1 row_rd in reset", int'(row_rd), 0);
      chk(ser_out == 1'b0, "R1 ser_out in reset", int'(ser_out), 0);
   endtask

   task automatic t_single(input int r, input int c, input int d);
      logic [FW-1:0] f;
      bit got, quiet, seen;
      int exp_rd;
      dly[r][c] = d;
      clr_mon();
      send_cmd(8'h02, 1, 8'(r), 5'(c));
      seen = 0;
      for (int i = 0; i < 6 && !seen; i++) begin
         if (row_en != '0) seen = 1;
         else @(negedge clk);
      end
      chk(seen && row_en == TR'(1 << r), "R2 charge strobe row", int'(row_en), 1 << r);
      @(negedge clk);
      chk(row_en == '0 && row_rd == TR'(1 << r), "R3 read follows charge",
          int'(row_rd), 1 << r);
      get_frame(f, got, quiet);
      chk(got, "R9 single frame sent", int'(got), 1);
      chk(int'(f[39:32]) == r, "R6 row field", int'(f[39:32]), r);
      chk(int'(f[31:27]) == c, "R6 col field", int'(f[31:27]), c);
      chk(f[26:TW] == '0, "R6 pad zero", int'(f[26:TW]), 0);
      chk(int'(f[TW-1:0]) == expect_cnt(d), "R4 R5 count", int'(f[TW-1:0]), expect_cnt(d));
      exp_rd = (d < MAXC) ? d + 1 : MAXC;
      chk(rd_cycles == exp_rd, "R5 read window length", rd_cycles, exp_rd);
      chk(quiet, "R11 strobes quiet during frame", int'(quiet), 1);
      repeat (60) @(negedge clk);
      chk(en_pulses == 1, "R9 back to idle after one pixel", en_pulses, 1);
   endtask

   task automatic t_scan();
      logic [FW-1:0] f;
      bit got, quiet;
      for (int r = 0; r < TR; r++)
         for (int c = 0; c < TC; c++) dly[r][c] = (r * 11 + c * 7) % 40;
      dly[3][1] = 100;
      dly[2][0] = MAXC;
      clr_mon();
      send_cmd(8'h01, 0, 8'd0, 5'd0);
      for (int r = 0; r < TR; r++)
         for (int c = 0; c < TC; c++) begin
            get_frame(f, got, quiet);
            if (r == 0 && c == 0) chk(got, "R8 scan command starts", int'(got), 1);
            chk(got && int'(f[39:32]) == r && int'(f[31:27]) == c,
                "R7 scan order", int'({f[39:32], f[31:27]}), r * 32 + c);
            chk(int'(f[TW-1:0]) == expect_cnt(dly[r][c]), "R4 scan count",
                int'(f[TW-1:0]), expect_cnt(dly[r][c]));
            chk(quiet, "R11 scan quiet during frame", int'(quiet), 1);
         end
      repeat (60) @(negedge clk);
      chk(en_pulses == TR * TC, "R7 one charge per pixel", en_pulses, TR * TC);
   endtask

   task automatic t_ignore(input logic [7:0] op, input int r, input int c, input string tag);
      clr_mon();
      send_cmd(op, op == 8'h02, 8'(r), 5'(c));
      repeat (200) @(negedge clk);
      chk(en_pulses == 0, tag, en_pulses, 0);
      chk(tx_hi == 0, "R10 no frame", tx_hi, 0);
   endtask

   initial begin
      for (int r = 0; r < TR; r++)
         for (int c = 0; c < TC; c++) dly[r][c] = 0;
      for (int c = 0; c < TC; c++) left[c] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      chk(row_en == '0 && row_rd == '0 && !ser_out, "R1 idle after reset", 0, 0);
      t_single(1, 2, 5);
      t_single(3, 0, 0);
      t_single(0, 1, 200);
      t_single(2, 2, MAXC);
      t_single(2, 1, MAXC - 1);
      t_scan();
      t_ignore(8'h05, 0, 0, "R10 unknown command");
      t_ignore(8'h02, TR, 0, "R10 row out of range");
      t_ignore(8'h02, 0, TC, "R10 col out of range");
      t_single(0, 0, 9);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule